// File: doc/BRIEF.md
# CPU Address Decoder and Register Router

This block sits on the processor's 16-bit address bus. For each access it turns the address and the read or write strobe into one select for the unit that owns that address: the local work RAM, the video register file, the audio and frame-counter registers, the sprite DMA trigger, the two controller ports, or cartridge space. For reads it returns the byte of the selected source. Unmapped holes read zero and swallow writes. The decode is purely combinational. The only storage is the 2 KB work RAM, which the block contains.

The block also owns two timing rules on the interrupt line. Both depend on when an access falls relative to the video unit.

- **Status read near the raster start.** A status read that lands on video cycle 2 or 3 raises a suppress pulse for the processor's NMI input.
- **Control-register write.** A write that turns NMI off while the scheduler's late flag is set also raises the suppress pulse. A write that turns NMI on while the video unit is in vertical blank raises a delayed-NMI pulse.

Both pulses are asserted in the same cycle as the access that causes them.

Top module: `cpu_addr_router`

## Requirements
- R1: Any access in 0x0000–0x1FFF reaches the 2 KB work RAM through address bits [10:0]. A byte written there reads back at the same offset in all four mirrors, in the cycle after the write.
- R2: Any access in 0x2000–0x3FFF addresses video register `cpu_addr[2:0]`, shown on `vid_reg`. `vid_sel` is raised for reads of offsets 2, 4 and 7 and for writes to every offset except 2. A read with `vid_sel` set returns `vid_rdata`.
- R3: In the video window, reads of offsets 0, 1, 3, 5 and 6 return zero with no select raised. A write to offset 2 raises no select.
- R4: A read of video offset 2 while `vid_cycle` is 2 or 3 drives `nmi_suppress` high in that cycle. The same read on any other cycle value does not.
- R5: A write to video offset 0 with `cpu_wdata[7]` (the NMI enable bit) at 0 while `late_flag` is 1 drives `nmi_suppress` high in that cycle.
- R6: A write to video offset 0 with `vid_nmi_en` at 0, `cpu_wdata[7]` at 1 and `vid_vblank` at 1 drives `nmi_delayed` high in that cycle. In every other case `nmi_delayed` is low.
- R7: A read of 0x4015 raises `aud_sel` and returns `aud_rdata`. Reads of 0x4016 and 0x4017 raise `joy_sel`, with `joy_port` equal to address bit 0, and return that controller's byte. An absent controller reads zero.
- R8: Every other read in 0x4000–0x4FFF returns zero and raises no select.
- R9: A write to 0x4014 raises `dma_sel`. A write to 0x4016 raises `joy_sel`, which strobes both ports. `aud_sel` is raised, with `aud_reg = cpu_addr[4:0]`, for writes to 0x4000–0x4008, 0x400A–0x400C, 0x400E–0x4013, 0x4015 and 0x4017 (the frame counter). Other writes in 0x4000–0x4FFF raise no select.
- R10: Accesses in 0x5000–0x5FFF raise no select, and reads there return zero.
- R11: Any access in 0x6000–0xFFFF raises `cart_sel`, and a read there returns `cart_rdata`.
- R12: At most one of `vid_sel`, `aud_sel`, `dma_sel`, `joy_sel` and `cart_sel` is high in any cycle. With neither strobe high, all selects, both NMI pulses and `cpu_rdata` are zero, and the two NMI pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data from the selected source |
| vid_sel | output | 1 | Video register select |
| vid_reg | output | 3 | Video register offset |
| vid_rdata | input | 8 | Video register read data |
| vid_cycle | input | 9 | Video unit's current cycle count |
| vid_nmi_en | input | 1 | NMI enable bit as it stands before the write |
| vid_vblank | input | 1 | Video unit is in vertical blank |
| late_flag | input | 1 | Scheduler: vblank set after the first video step of this tick |
| nmi_suppress | output | 1 | Pulse that cancels a pending NMI |
| nmi_delayed | output | 1 | Pulse that raises an NMI one instruction late |
| aud_sel | output | 1 | Audio / frame-counter register select |
| aud_reg | output | 5 | Audio register offset |
| aud_rdata | input | 8 | Audio status byte |
| dma_sel | output | 1 | Sprite DMA trigger |
| joy_sel | output | 1 | Controller port select |
| joy_port | output | 1 | Controller index for reads |
| joy1_data | input | 8 | Controller 1 read byte |
| joy2_data | input | 8 | Controller 2 read byte |
| joy1_present | input | 1 | Controller 1 attached |
| joy2_present | input | 1 | Controller 2 attached |
| cart_sel | output | 1 | Cartridge space select |
| cart_rdata | input | 8 | Cartridge read data |

## Verification
The only state is the work RAM. A wrong index or a lost write shows up on the first read of that byte or of one of its mirrors, one cycle after the write. Decode faults show up at once, in the same cycle as the access: a select on the wrong region, a missing select, or a non-zero byte from a hole. So does a wrong NMI rule: a pulse with the wrong cycle window, a wrong enable polarity or a missing vblank or late-flag condition. For this reason the bench compares every output against its model on each access cycle.

// File: rtl/addr_router_pkg.sv
package addr_router_pkg;

  typedef enum logic [2:0] {
    RG_RAM,
    RG_VID,
    RG_IO,
    RG_OPEN,
    RG_CART
  } region_e;

  localparam logic [2:0]  VOFF_CTRL   = 3'd0;
  localparam logic [2:0]  VOFF_STATUS = 3'd2;
  localparam logic [15:0] IO_DMA      = 16'h4014;
  localparam logic [15:0] IO_AUD_STAT = 16'h4015;
  localparam logic [15:0] IO_JOY1     = 16'h4016;
  localparam logic [15:0] IO_JOY2     = 16'h4017;

  // The top nibble of the address picks the region.
  function automatic region_e region_of(input logic [15:0] a);
    region_e r;
    case (a[15:12])
      4'h0, 4'h1: r = RG_RAM;
      4'h2, 4'h3: r = RG_VID;
      4'h4:       r = RG_IO;
      4'h5:       r = RG_OPEN;
      default:    r = RG_CART;
    endcase
    return r;
  endfunction

  // Only status, sprite data and data are readable.
  function automatic logic vid_readable(input logic [2:0] off);
    return (off == 3'd2) || (off == 3'd4) || (off == 3'd7);
  endfunction

  // Audio write targets: channel registers (two gaps), enable, frame counter.
  function automatic logic is_audio_wr_target(input logic [15:0] a);
    logic [4:0] lo;
    lo = a[4:0];
    return (a[15:5] == 11'h200) &&
           (((lo <= 5'h13) && (lo != 5'h09) && (lo != 5'h0D)) ||
            (lo == 5'h15) || (lo == 5'h17));
  endfunction

endpackage

// File: rtl/route_decode.sv
module route_decode
  import addr_router_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  output region_e     region,
  output logic        ram_sel,
  output logic        vid_sel,
  output logic        aud_sel,
  output logic        dma_sel,
  output logic        joy_sel,
  output logic        cart_sel,
  output logic        status_rd,
  output logic        ctl_wr
);

  logic       acc;
  logic [2:0] voff;

  assign acc    = cpu_rd | cpu_wr;
  assign region = region_of(cpu_addr);
  assign voff   = cpu_addr[2:0];

  always_comb begin
    ram_sel  = 1'b0;
    vid_sel  = 1'b0;
    aud_sel  = 1'b0;
    dma_sel  = 1'b0;
    joy_sel  = 1'b0;
    cart_sel = 1'b0;
    unique case (region)
      RG_RAM:  ram_sel = acc;
      RG_VID:  vid_sel = (cpu_rd && vid_readable(voff)) ||
                         (cpu_wr && (voff != VOFF_STATUS));
      RG_IO: begin
        aud_sel = (cpu_rd && (cpu_addr == IO_AUD_STAT)) ||
                  (cpu_wr && is_audio_wr_target(cpu_addr));
        dma_sel = cpu_wr && (cpu_addr == IO_DMA);
        joy_sel = (cpu_rd && ((cpu_addr == IO_JOY1) || (cpu_addr == IO_JOY2))) ||
                  (cpu_wr && (cpu_addr == IO_JOY1));
      end
      RG_CART: cart_sel = acc;
      default: ;
    endcase
  end

  assign status_rd = cpu_rd && (region == RG_VID) && (voff == VOFF_STATUS);
  assign ctl_wr    = cpu_wr && (region == RG_VID) && (voff == VOFF_CTRL);

  // R12
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, vid_sel, aud_sel, dma_sel, joy_sel, cart_sel}));

  // R3
  status_wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_rd && cpu_addr[15:13] == 3'b001 && cpu_addr[2:0] == 3'd2)
      |-> !vid_sel);

  // R10
  open_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:12] == 4'h5)
      |-> !(ram_sel || vid_sel || aud_sel || dma_sel || joy_sel || cart_sel));

  // R9
  dma_only_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_sel |-> (cpu_wr && cpu_addr[15:12] == 4'h4 && cpu_addr[7:0] == 8'h14));

endmodule

// File: rtl/work_ram.sv
module work_ram #(
  parameter int DEPTH = 2048,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/nmi_rules.sv
module nmi_rules #(
  parameter int DW         = 8,
  parameter int CYC_W      = 9,
  parameter int EN_BIT     = 7,
  parameter int SUP_FIRST  = 2,
  parameter int SUP_LAST   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             status_rd,
  input  logic             ctl_wr,
  input  logic [DW-1:0]    wdata,
  input  logic [CYC_W-1:0] vid_cycle,
  input  logic             vid_nmi_en,
  input  logic             vid_vblank,
  input  logic             late_flag,
  output logic             nmi_suppress,
  output logic             nmi_delayed
);

  localparam logic [CYC_W-1:0] WIN_LO = CYC_W'(SUP_FIRST);
  localparam logic [CYC_W-1:0] WIN_HI = CYC_W'(SUP_LAST);

  logic in_window;
  logic new_en;
  logic race_cut;
  logic disable_cut;

  assign in_window   = (vid_cycle >= WIN_LO) && (vid_cycle <= WIN_HI);
  assign new_en      = wdata[EN_BIT];
  assign race_cut    = status_rd && in_window;
  assign disable_cut = ctl_wr && !new_en && late_flag;

  assign nmi_suppress = race_cut || disable_cut;
  assign nmi_delayed  = ctl_wr && !vid_nmi_en && new_en && vid_vblank;

  // R4 R5
  suppress_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_suppress |-> (status_rd || (ctl_wr && late_flag)));

  // R6
  delayed_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_delayed |-> (ctl_wr && vid_vblank && !vid_nmi_en));

  // R12
  nmi_pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_suppress && nmi_delayed));

endmodule

// File: rtl/cpu_addr_router.sv
module cpu_addr_router
  import addr_router_pkg::*;
#(
  parameter int RAM_BYTES  = 2048,
  parameter int DATA_W     = 8,
  parameter int CYC_W      = 9,
  parameter int NMI_EN_BIT = 7,
  parameter int SUP_FIRST  = 2,
  parameter int SUP_LAST   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              vid_sel,
  output logic [2:0]        vid_reg,
  input  logic [DATA_W-1:0] vid_rdata,
  input  logic [CYC_W-1:0]  vid_cycle,
  input  logic              vid_nmi_en,
  input  logic              vid_vblank,
  input  logic              late_flag,
  output logic              nmi_suppress,
  output logic              nmi_delayed,
  output logic              aud_sel,
  output logic [4:0]        aud_reg,
  input  logic [DATA_W-1:0] aud_rdata,
  output logic              dma_sel,
  output logic              joy_sel,
  output logic              joy_port,
  input  logic [DATA_W-1:0] joy1_data,
  input  logic [DATA_W-1:0] joy2_data,
  input  logic              joy1_present,
  input  logic              joy2_present,
  output logic              cart_sel,
  input  logic [DATA_W-1:0] cart_rdata
);

  localparam int RAM_AW    = $clog2(RAM_BYTES);
  localparam int JOY_PORTS = 2;

  region_e           region;
  logic              ram_sel;
  logic              status_rd;
  logic              ctl_wr;
  logic [DATA_W-1:0] ram_q;
  logic [JOY_PORTS-1:0][DATA_W-1:0] joy_in;
  logic [JOY_PORTS-1:0][DATA_W-1:0] joy_q;
  logic [JOY_PORTS-1:0]             joy_here;

  route_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .region    (region),
    .ram_sel   (ram_sel),
    .vid_sel   (vid_sel),
    .aud_sel   (aud_sel),
    .dma_sel   (dma_sel),
    .joy_sel   (joy_sel),
    .cart_sel  (cart_sel),
    .status_rd (status_rd),
    .ctl_wr    (ctl_wr)
  );

  work_ram #(
    .DEPTH (RAM_BYTES),
    .DW    (DATA_W)
  ) u_ram (
    .clk   (clk),
    .we    (cpu_wr && ram_sel),
    .addr  (cpu_addr[RAM_AW-1:0]),
    .wdata (cpu_wdata),
    .rdata (ram_q)
  );

  nmi_rules #(
    .DW        (DATA_W),
    .CYC_W     (CYC_W),
    .EN_BIT    (NMI_EN_BIT),
    .SUP_FIRST (SUP_FIRST),
    .SUP_LAST  (SUP_LAST)
  ) u_nmi (
    .clk          (clk),
    .rst_n        (rst_n),
    .status_rd    (status_rd),
    .ctl_wr       (ctl_wr),
    .wdata        (cpu_wdata),
    .vid_cycle    (vid_cycle),
    .vid_nmi_en   (vid_nmi_en),
    .vid_vblank   (vid_vblank),
    .late_flag    (late_flag),
    .nmi_suppress (nmi_suppress),
    .nmi_delayed  (nmi_delayed)
  );

  assign vid_reg  = cpu_addr[2:0];
  assign aud_reg  = cpu_addr[4:0];
  assign joy_port = cpu_addr[0];

  assign joy_in   = {joy2_data, joy1_data};
  assign joy_here = {joy2_present, joy1_present};

  for (genvar g = 0; g < JOY_PORTS; g++) begin : g_joy
    assign joy_q[g] = joy_here[g] ? joy_in[g] : '0;
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_rd) begin
      if (ram_sel)       cpu_rdata = ram_q;
      else if (vid_sel)  cpu_rdata = vid_rdata;
      else if (aud_sel)  cpu_rdata = aud_rdata;
      else if (joy_sel)  cpu_rdata = joy_q[cpu_addr[0]];
      else if (cart_sel) cpu_rdata = cart_rdata;
    end
  end

  // R8
  io_hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr[15:12] == 4'h4 &&
     cpu_addr != IO_AUD_STAT && cpu_addr != IO_JOY1 && cpu_addr != IO_JOY2)
      |-> (cpu_rdata == '0));

  // R11
  cart_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cart_sel) |-> (cpu_rdata == cart_rdata));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rd && !cpu_wr)
      |-> (cpu_rdata == '0 && !nmi_suppress && !nmi_delayed &&
           !vid_sel && !aud_sel && !dma_sel && !joy_sel && !cart_sel));

endmodule

// File: tb/cpu_addr_router_bench.sv
module cpu_addr_router_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic        vid_sel;
  logic [2:0]  vid_reg;
  logic [7:0]  vid_rdata;
  logic [8:0]  vid_cycle;
  logic        vid_nmi_en, vid_vblank, late_flag;
  logic        nmi_suppress, nmi_delayed;
  logic        aud_sel;
  logic [4:0]  aud_reg;
  logic [7:0]  aud_rdata;
  logic        dma_sel, joy_sel, joy_port;
  logic [7:0]  joy1_data, joy2_data;
  logic        joy1_present, joy2_present;
  logic        cart_sel;
  logic [7:0]  cart_rdata;

  cpu_addr_router u_cpu_addr_router (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .vid_sel(vid_sel), .vid_reg(vid_reg), .vid_rdata(vid_rdata),
    .vid_cycle(vid_cycle), .vid_nmi_en(vid_nmi_en), .vid_vblank(vid_vblank),
    .late_flag(late_flag), .nmi_suppress(nmi_suppress), .nmi_delayed(nmi_delayed),
    .aud_sel(aud_sel), .aud_reg(aud_reg), .aud_rdata(aud_rdata),
    .dma_sel(dma_sel), .joy_sel(joy_sel), .joy_port(joy_port),
    .joy1_data(joy1_data), .joy2_data(joy2_data),
    .joy1_present(joy1_present), .joy2_present(joy2_present),
    .cart_sel(cart_sel), .cart_rdata(cart_rdata)
  );

  int errors = 0;
  int checks = 0;
  logic [7:0] ram_m [int];

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Drive one access, compare against the model, then commit on the edge.
  task automatic access(string req, bit rd, bit wr, int a, int d);
    int  off;
    bit  in_vid;
    bit  e_vid, e_aud, e_dma, e_joy, e_cart, e_sup, e_del;
    int  e_rd;
    bit  known;
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_addr = 16'(a); cpu_wdata = 8'(d);
    #2;
    off    = a % 8;
    in_vid = (a >= 'h2000) && (a < 'h4000);
    e_vid  = in_vid && ((rd && (off == 2 || off == 4 || off == 7)) || (wr && off != 2));
    e_aud  = (rd && a == 'h4015) ||
             (wr && ((a >= 'h4000 && a <= 'h4013 && a != 'h4009 && a != 'h400D) ||
                     a == 'h4015 || a == 'h4017));
    e_dma  = wr && (a == 'h4014);
    e_joy  = (rd && (a == 'h4016 || a == 'h4017)) || (wr && a == 'h4016);
    e_cart = (rd || wr) && (a >= 'h6000);
    e_sup  = (rd && in_vid && off == 2 && (vid_cycle == 2 || vid_cycle == 3)) ||
             (wr && in_vid && off == 0 && d < 128 && late_flag);
    e_del  = wr && in_vid && off == 0 && d >= 128 && !vid_nmi_en && vid_vblank;
    known  = 1'b1;
    e_rd   = 0;
    if (rd) begin
      if (a < 'h2000) begin
        if (ram_m.exists(a % 2048)) e_rd = int'(ram_m[a % 2048]);
        else known = 1'b0;
      end
      else if (e_vid)  e_rd = int'(vid_rdata);
      else if (e_aud)  e_rd = int'(aud_rdata);
      else if (e_joy)  e_rd = (a == 'h4016) ? (joy1_present ? int'(joy1_data) : 0)
                                            : (joy2_present ? int'(joy2_data) : 0);
      else if (e_cart) e_rd = int'(cart_rdata);
    end
    if (known) check(req, "rdata", int'(cpu_rdata), e_rd);
    check(req, "selects", int'({vid_sel, aud_sel, dma_sel, joy_sel, cart_sel}),
          int'({e_vid, e_aud, e_dma, e_joy, e_cart}));
    check("R12", "select count", ($countones({vid_sel, aud_sel, dma_sel, joy_sel, cart_sel}) <= 1) ? 1 : 0, 1);
    if (e_vid) check(req, "vid_reg", int'(vid_reg), off);
    if (e_aud) check(req, "aud_reg", int'(aud_reg), a % 32);
    if (e_joy) check(req, "joy_port", int'(joy_port), a % 2);
    check(req, "nmi_suppress", int'(nmi_suppress), int'(e_sup));
    check(req, "nmi_delayed", int'(nmi_delayed), int'(e_del));
    @(posedge clk);
    if (wr && a < 'h2000) ram_m[a % 2048] = 8'(d);
  endtask

  task automatic idle(string req);
    @(negedge clk);
    cpu_rd = 0; cpu_wr = 0;
    #2;
    check(req, "idle rdata", int'(cpu_rdata), 0);
    check(req, "idle selects", int'({vid_sel, aud_sel, dma_sel, joy_sel, cart_sel, nmi_suppress, nmi_delayed}), 0);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL R12 watchdog act=1 exp=0");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; cpu_addr = 0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = 0;
    vid_rdata = 8'h6D; vid_cycle = 9'd100; vid_nmi_en = 0; vid_vblank = 0; late_flag = 0;
    aud_rdata = 8'h3C; joy1_data = 8'h01; joy2_data = 8'h40;
    joy1_present = 1; joy2_present = 1; cart_rdata = 8'hC7;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle("R12");

    // R1: RAM and its mirrors
    access("R1", 0, 1, 'h0123, 'h5A);
    for (int m = 0; m < 4; m++) access("R1", 1, 0, 'h0123 + m * 'h800, 0);
    access("R1", 0, 1, 'h1FFF, 'h81);
    access("R1", 1, 0, 'h07FF, 0);
    access("R1", 0, 1, 'h0800, 'hE2);
    access("R1", 1, 0, 'h1800, 0);
    access("R1", 1, 0, 'h0123, 0);

    // R2 R3: video window reads and writes, base and mirror
    for (int o = 0; o < 8; o++) access(o == 2 || o == 4 || o == 7 ? "R2" : "R3", 1, 0, 'h2000 + o, 0);
    vid_rdata = 8'h92;
    for (int o = 0; o < 8; o++) access(o == 2 ? "R3" : "R2", 1, 0, 'h3FF8 + o, 0);
    for (int o = 1; o < 8; o++) access(o == 2 ? "R3" : "R2", 0, 1, 'h2468 + o, 'h11 * o);

    // R4: status read around the race window
    for (int c = 0; c < 6; c++) begin
      vid_cycle = 9'(c);
      access("R4", 1, 0, 'h2002, 0);
      access("R4", 1, 0, 'h3F12, 0);
    end
    vid_cycle = 9'd100;

    // R5: control write that disables NMI with the late flag
    late_flag = 1;
    access("R5", 0, 1, 'h2000, 'h00);
    access("R5", 0, 1, 'h3FF0, 'h7F);
    access("R5", 0, 1, 'h2000, 'h80);
    late_flag = 0;
    access("R5", 0, 1, 'h2000, 'h00);

    // R6: enabling NMI during vblank
    vid_vblank = 1; vid_nmi_en = 0;
    access("R6", 0, 1, 'h2000, 'h80);
    access("R6", 0, 1, 'h3008, 'hFF);
    vid_nmi_en = 1;
    access("R6", 0, 1, 'h2000, 'h80);
    vid_nmi_en = 0; vid_vblank = 0;
    access("R6", 0, 1, 'h2000, 'h80);
    vid_vblank = 1; late_flag = 1;
    access("R6", 0, 1, 'h2008, 'h00);
    vid_vblank = 0; late_flag = 0;

    // R7: audio status and controllers, presence
    access("R7", 1, 0, 'h4015, 0);
    access("R7", 1, 0, 'h4016, 0);
    access("R7", 1, 0, 'h4017, 0);
    joy1_present = 0;
    access("R7", 1, 0, 'h4016, 0);
    access("R7", 1, 0, 'h4017, 0);
    joy1_present = 1; joy2_present = 0;
    access("R7", 1, 0, 'h4017, 0);
    access("R7", 1, 0, 'h4016, 0);
    joy2_present = 1;

    // R8: IO holes read zero
    access("R8", 1, 0, 'h4000, 0);
    access("R8", 1, 0, 'h4014, 0);
    access("R8", 1, 0, 'h4018, 0);
    access("R8", 1, 0, 'h4FFF, 0);
    access("R8", 1, 0, 'h4415, 0);

    // R9: IO writes
    access("R9", 0, 1, 'h4014, 'h02);
    access("R9", 0, 1, 'h4016, 'h01);
    access("R9", 0, 1, 'h4000, 'h30);
    access("R9", 0, 1, 'h4013, 'h30);
    access("R9", 0, 1, 'h4009, 'h30);
    access("R9", 0, 1, 'h400D, 'h30);
    access("R9", 0, 1, 'h4015, 'h0F);
    access("R9", 0, 1, 'h4017, 'h40);
    access("R9", 0, 1, 'h4018, 'h40);
    access("R9", 0, 1, 'h4815, 'h40);

    // R10: open region
    access("R10", 1, 0, 'h5000, 0);
    access("R10", 0, 1, 'h5ABC, 'h99);
    access("R10", 1, 0, 'h5FFF, 0);

    // R11: cartridge space
    access("R11", 1, 0, 'h6000, 0);
    cart_rdata = 8'h3E;
    access("R11", 1, 0, 'hFFFF, 0);
    access("R11", 0, 1, 'h8000, 'h12);

    // R1 again: RAM untouched by all the other traffic
    access("R1", 1, 0, 'h0923, 0);
    idle("R12");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule